// File: doc/BRIEF.md
# Read-Sequence Store/Recall Key Detector

This block sits beside the control decode of an asynchronous-style memory port and watches ordinary read accesses for a fixed, ordered series of six addresses. Five common addresses open the series; the sixth address picks the action. One address asks for the working RAM to be saved into nonvolatile storage, the other asks for the nonvolatile copy to be restored into the RAM. When the series completes, the block raises a one-cycle request pulse for the nonvolatile sequencer. The block does not carry out the save or restore.

Each access reaches the block as a synchronous strobe, already derived from the falling edge of chip enable, together with the write-enable level and the address. Only the low 14 address bits take part in matching. A write anywhere in the series, or a read at an address that does not fit the next step, cancels the series silently. A read at the first key address always starts a fresh series, even when it arrives in the middle of a broken one. While the sequencer reports that it is busy, the block ignores strobes and holds its progress at idle.

Top module: `nv_key_detect`

## Requirements
- R1: Out of reset and after reset release, both request outputs are low and the progress is idle, so the last five key addresses alone (without the first) raise no request.
- R2: Reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, then 0x0FC0 (low 14 bits, write enable high on each) raise store_req for exactly one cycle, in the cycle after the clock edge that samples the sixth strobe.
- R3: The same five reads followed by a read at 0x0C63 raise recall_req for exactly one cycle, in the cycle after the sixth strobe.
- R4: Address bit 14 takes no part in matching: the key with bit 14 set on any step gives the same request as with it clear.
- R5: A strobe with write enable low (a write) at any step, at any address, cancels the series; the remaining key reads then raise no request.
- R6: A read at an address that is not the next expected one cancels the series, including a wrong sixth address; no request follows.
- R7: A read at 0x0E38 that cancels a series counts as the first step of a new series, so the next five key reads complete it.
- R8: The output-enable level has no effect: a key read with output enable high or low counts the same.
- R9: While busy is high, strobes are ignored and progress is forced to idle, so a series that was under way when busy rose cannot be finished afterwards.
- R10: After a request pulse the progress is idle; repeating the sixth address, or the last two steps, raises nothing.
- R11: store_req and recall_req are never high together, and neither is high two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_fall | input | 1 | One-cycle strobe marking a chip-enable falling edge (one access) |
| we_n | input | 1 | Write-enable level sampled with the strobe; high means a read |
| oe_n | input | 1 | Output-enable level; does not affect detection |
| addr | input | 15 | Access address; bits 13..0 are compared |
| busy | input | 1 | High while the nonvolatile sequencer is working |
| store_req | output | 1 | One-cycle pulse requesting a save to nonvolatile storage |
| recall_req | output | 1 | One-cycle pulse requesting a restore from nonvolatile storage |

## Verification
The bench puts a write at every one of the six step positions, since a design that only checked the read flag on the final step would still fire after a write in the middle. It breaks a series with 0x0E38 itself, where a design without the restart rule would discard that read and miss the following key, and with a wrong final address, where a loose decode of the last step would fire anyway. It raises busy between steps without any strobe, which catches a design that merely drops strobes instead of clearing progress, and it repeats the tail of the key just after a request, which catches a counter that is not returned to idle and would fire twice.

// File: rtl/nvk_pkg.sv
package nvk_pkg;
  localparam int KEY_W    = 14;
  localparam int SEQ_LEN  = 6;
  localparam int STEP_W   = $clog2(SEQ_LEN + 1);
  localparam int N_PAT    = SEQ_LEN + 1;
  localparam int LAST_STEP = SEQ_LEN - 1;
  localparam int STORE_IDX  = SEQ_LEN - 1;
  localparam int RECALL_IDX = SEQ_LEN;

  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_STORE  = 2'd1,
    REQ_RECALL = 2'd2
  } req_e;

  // Pattern table: indices 0..4 are the shared prefix, 5 is the save
  // terminator, 6 is the restore terminator.
  function automatic logic [KEY_W-1:0] key_addr(input int idx);
    logic [KEY_W-1:0] v;
    case (idx)
      0:       v = 14'h0E38;
      1:       v = 14'h31C7;
      2:       v = 14'h03E0;
      3:       v = 14'h3C1F;
      4:       v = 14'h303F;
      5:       v = 14'h0FC0;
      6:       v = 14'h0C63;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/nvk_match.sv
module nvk_match
  import nvk_pkg::*;
(
  input  logic [KEY_W-1:0] addr_lo,
  output logic [N_PAT-1:0] hit
);
  for (genvar g = 0; g < N_PAT; g++) begin : g_cmp
    assign hit[g] = (addr_lo == key_addr(g));
  end
endmodule

// File: rtl/nvk_seq_fsm.sv
module nvk_seq_fsm
  import nvk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              is_read,
  input  logic              busy,
  input  logic [N_PAT-1:0]  hit,
  output logic [STEP_W-1:0] step_q,
  output logic              advance,
  output logic              cancel,
  output req_e              fire
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(LAST_STEP);

  logic [STEP_W-1:0] step_d;
  logic              expect_hit;
  logic              term_store;
  logic              term_recall;

  assign expect_hit  = (step_q < LAST) && hit[step_q];
  assign term_store  = (step_q == LAST) && hit[STORE_IDX];
  assign term_recall = (step_q == LAST) && hit[RECALL_IDX];

  always_comb begin
    step_d  = step_q;
    fire    = REQ_NONE;
    advance = 1'b0;
    cancel  = 1'b0;
    if (busy) begin
      step_d = '0;
    end else if (strobe) begin
      if (!is_read) begin
        step_d = '0;
        cancel = 1'b1;
      end else if (expect_hit) begin
        step_d  = step_q + 1'b1;
        advance = 1'b1;
      end else if (term_store) begin
        step_d = '0;
        fire   = REQ_STORE;
      end else if (term_recall) begin
        step_d = '0;
        fire   = REQ_RECALL;
      end else begin
        cancel = 1'b1;
        step_d = hit[0] ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end
endmodule

// File: rtl/nvk_pulse_out.sv
module nvk_pulse_out
  import nvk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  req_e fire,
  output logic store_req,
  output logic recall_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= (fire == REQ_STORE);
      recall_req <= (fire == REQ_RECALL);
    end
  end
endmodule

// File: rtl/nv_key_detect.sv
module nv_key_detect
  import nvk_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_fall,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              store_req,
  output logic              recall_req
);
  logic [N_PAT-1:0]  hit;
  logic [STEP_W-1:0] step_q;
  logic              advance;
  logic              cancel;
  req_e              fire;

  nvk_match u_match (
    .addr_lo (addr[KEY_W-1:0]),
    .hit     (hit)
  );

  nvk_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (ce_fall),
    .is_read (we_n),
    .busy    (busy),
    .hit     (hit),
    .step_q  (step_q),
    .advance (advance),
    .cancel  (cancel),
    .fire    (fire)
  );

  nvk_pulse_out u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .store_req  (store_req),
    .recall_req (recall_req)
  );
endmodule

// File: rtl/nvk_checker.sv
module nvk_checker
  import nvk_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_fall,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic [STEP_W-1:0] step_q,
  input logic              advance,
  input logic              cancel,
  input logic              store_req,
  input logic              recall_req
);
  // R1: progress never leaves the legal range
  a_r1_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_W'(LAST_STEP));

  // R2: a save pulse only follows an accepted read strobe
  a_r2_store_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> $past(ce_fall && we_n && !busy));

  // R3: a restore pulse only follows an accepted read strobe
  a_r3_recall_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> $past(ce_fall && we_n && !busy));

  // R5: a write strobe leaves the progress idle
  a_r5_write_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && !we_n && !busy) |=> (step_q == '0 && !store_req && !recall_req));

  // R6: a cancel leaves at most the restart step
  a_r6_cancel_low: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (step_q <= STEP_W'(1)));

  // R9: busy forces idle and suppresses pulses
  a_r9_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (step_q == '0 && !store_req && !recall_req));

  // R10: a request pulse comes with idle progress
  a_r10_idle_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> (step_q == '0));

  // R11: exclusive, single-cycle pulses
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |=> !(store_req || recall_req));

  // R7: advancing always raises the step by one
  a_r7_advance_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (step_q == $past(step_q) + 1'b1));

  // R8: sampled access inputs are driven
  a_r8_inputs_known: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall |-> !$isunknown({oe_n, addr, we_n}));
endmodule

bind nv_key_detect nvk_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_fall    (ce_fall),
  .we_n       (we_n),
  .oe_n       (oe_n),
  .addr       (addr),
  .busy       (busy),
  .step_q     (step_q),
  .advance    (advance),
  .cancel     (cancel),
  .store_req  (store_req),
  .recall_req (recall_req)
);

// File: tb/sim_nv_key_detect.sv
module sim_nv_key_detect;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_fall = 1'b0;
  logic        we_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [14:0] addr = '0;
  logic        busy = 1'b0;
  logic        store_req;
  logic        recall_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nv_key_detect u0 (
    .clk(clk), .rst_n(rst_n), .ce_fall(ce_fall), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .busy(busy), .store_req(store_req), .recall_req(recall_req)
  );

  // Behavioural reference: how many key steps have been seen.
  logic [13:0] prefix[$] = '{14'h0E38, 14'h31C7, 14'h03E0, 14'h3C1F, 14'h303F};
  localparam logic [13:0] SAVE_A = 14'h0FC0;
  localparam logic [13:0] LOAD_A = 14'h0C63;
  int seen = 0;

  task automatic model(input bit stb, input bit rd, input logic [14:0] a,
                       input bit bsy, output bit es, output bit er);
    logic [13:0] lo;
    lo = a[13:0];
    es = 0; er = 0;
    if (bsy) seen = 0;
    else if (stb) begin
      if (!rd) seen = 0;
      else if (seen < prefix.size() && lo == prefix[seen]) seen++;
      else if (seen == prefix.size() && lo == SAVE_A) begin es = 1; seen = 0; end
      else if (seen == prefix.size() && lo == LOAD_A) begin er = 1; seen = 0; end
      else seen = (lo == prefix[0]) ? 1 : 0;
    end
  endtask

  task automatic check(input string tag, input bit es, input bit er);
    total++;
    if (store_req !== es || recall_req !== er) begin
      bad++;
      $display("FAIL %s: store/recall actual=%b%b expected=%b%b", tag,
               store_req, recall_req, es, er);
    end
  endtask

  // One clock: drive at a falling edge, check at the next falling edge.
  task automatic cyc(input bit stb, input logic [14:0] a, input bit wn,
                     input bit on, input bit bsy, input string tag);
    bit es, er;
    ce_fall = stb; addr = a; we_n = wn; oe_n = on; busy = bsy;
    model(stb, wn, a, bsy, es, er);
    @(negedge clk);
    check(tag, es, er);
  endtask

  task automatic rd(input logic [13:0] a, input string tag);
    cyc(1, {1'b0, a}, 1, 0, 0, tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 15'h0, 1, 1, 0, tag);
  endtask

  task automatic prefix_reads(input string tag);
    foreach (prefix[i]) rd(prefix[i], tag);
  endtask

  task automatic finish;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 0);
    rst_n = 1'b1;
    idle("R1 after reset");
    // R1: tail of the key alone does nothing
    for (int i = 1; i < 5; i++) rd(prefix[i], "R1 tail");
    rd(SAVE_A, "R1 tail end");
    idle("R1 quiet");

    // R2 full save key, then R11 single cycle
    prefix_reads("R2 prefix");
    rd(SAVE_A, "R2 store pulse");
    idle("R11 pulse ends");

    // R3 full restore key with idle gaps
    foreach (prefix[i]) begin rd(prefix[i], "R3 prefix"); idle("R3 gap"); end
    rd(LOAD_A, "R3 recall pulse");
    idle("R11 recall ends");

    // R4 bit 14 set on every step
    foreach (prefix[i]) cyc(1, {1'b1, prefix[i]}, 1, 0, 0, "R4 prefix");
    cyc(1, {1'b1, SAVE_A}, 1, 0, 0, "R4 store bit14");

    // R8 output enable high throughout
    foreach (prefix[i]) cyc(1, {1'b0, prefix[i]}, 1, 1, 0, "R8 prefix");
    cyc(1, {1'b0, LOAD_A}, 1, 1, 0, "R8 recall oe high");

    // R5 write at each step position
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < k; i++) rd(prefix[i], "R5 before write");
      cyc(1, {1'b0, (k < 5) ? prefix[k] : SAVE_A}, 0, 1, 0, "R5 write step");
      for (int i = k + 1; i < 5; i++) rd(prefix[i], "R5 after write");
      if (k < 5) rd(SAVE_A, "R5 no store");
      idle("R5 quiet");
    end

    // R6 wrong address mid series and wrong terminator
    rd(prefix[0], "R6"); rd(prefix[1], "R6"); rd(14'h1234, "R6 wrong mid");
    for (int i = 2; i < 5; i++) rd(prefix[i], "R6 after wrong");
    rd(SAVE_A, "R6 no store");
    prefix_reads("R6 prefix");
    rd(14'h0FC1, "R6 wrong sixth");
    rd(SAVE_A, "R6 late terminator");

    // R7 restart from the first key address
    rd(prefix[0], "R7"); rd(prefix[1], "R7"); rd(prefix[0], "R7 restart");
    for (int i = 1; i < 5; i++) rd(prefix[i], "R7 continue");
    rd(SAVE_A, "R7 store after restart");
    prefix_reads("R7 prefix");
    rd(prefix[0], "R7 restart at sixth");
    for (int i = 1; i < 5; i++) rd(prefix[i], "R7 continue");
    rd(LOAD_A, "R7 recall after restart");

    // R9 busy during a strobe, and busy without strobe
    rd(prefix[0], "R9"); rd(prefix[1], "R9");
    cyc(1, {1'b0, prefix[2]}, 1, 0, 1, "R9 strobe while busy");
    for (int i = 3; i < 5; i++) rd(prefix[i], "R9 after busy");
    rd(SAVE_A, "R9 no store");
    prefix_reads("R9 prefix");
    cyc(0, 15'h0, 1, 1, 1, "R9 busy no strobe");
    rd(LOAD_A, "R9 no recall");

    // R10 progress idle after a request
    prefix_reads("R10 prefix");
    rd(SAVE_A, "R10 store");
    rd(SAVE_A, "R10 repeat sixth");
    rd(prefix[4], "R10 repeat fifth"); rd(LOAD_A, "R10 repeat end");
    idle("R10 quiet");

    done = 1;
    finish();
  end
endmodule